// File: doc/BRIEF.md
# Two-Wire Serial Converter Result Reader

This block is the host side of a two-wire link to a delta-sigma converter whose chip select is tied low for good. With chip select held low, the converter's serial data line does two jobs. Between frames it shows conversion status: it is high while a conversion runs and low once a result is waiting. During a frame it carries the result bits. The reader holds the serial clock low from reset through a power-up delay. The converter sees a low clock at the end of its own power-on reset and so selects the externally clocked mode.

Once the delay has run out and reads are enabled, the reader watches the data line. A ready condition is two consecutive low samples. The reader then drives exactly 32 serial clock periods and samples the line on each rising edge. It presents the captured word with a one-cycle valid strobe. The first bit captured is the converter's end-of-conversion flag, which must be zero in a good frame. If it is one, the reader raises an error flag alongside the word. When the 32nd falling edge has passed, the converter begins a new conversion by itself. The reader goes back to waiting for the next ready condition, and a timeout flag reports a converter that never becomes ready.

Top module: `adc2w_reader`

## Requirements
- R1: From reset until PWRUP_CYCLES system clocks have elapsed, `sclk` stays low and `busy` stays low, whatever `enable` and `sdo_in` do. The first frame can begin no earlier than three cycles after that delay ends.
- R2: While `enable` is low, no frame starts and `sclk` stays low, even with `sdo_in` low.
- R3: A frame starts only after `sdo_in` has been sampled low on two consecutive system clock edges while waiting. A low lasting a single cycle does not start a frame.
- R4: `sclk` is low whenever no frame is in progress. During a frame, each high phase and each low phase lasts DIV_HALF system clocks. A frame holds exactly 32 rising edges and lasts 64*DIV_HALF cycles from the rise of `busy` to `data_valid`.
- R5: `sdo_in` is sampled in the system clock cycle in which `sclk` rises. The first bit sampled lands in `result[31]` and the last in `result[0]`.
- R6: `data_valid` is high for exactly one cycle per frame, in the cycle in which the new `result` first appears. At all other times `result` holds its value.
- R7: `frame_err` is updated together with `data_valid` and equals the first bit captured (`result[31]`), so a frame whose status bit reads 1 is flagged.
- R8: If no ready condition is seen within TIMEOUT_CYCLES cycles of waiting, `timeout_fault` goes high in the cycle after the last one. It stays high while waiting continues and clears when the next frame starts.
- R9: `busy` is high from the cycle a frame starts until its last falling `sclk` edge, and it is low in the `data_valid` cycle.
- R10: While `enable` stays high, the reader returns to waiting after each frame. It reads every following conversion once the line has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the reader to wait for and fetch results |
| sdo_in | input | 1 | Converter data line: status between frames, result bits in a frame |
| sclk | output | 1 | Serial clock to the converter, idle low |
| result | output | FRAME_BITS | Last captured frame, first bit in the MSB |
| data_valid | output | 1 | One-cycle strobe for a new result |
| busy | output | 1 | A frame is being clocked |
| frame_err | output | 1 | Status bit of the last frame read as 1 |
| timeout_fault | output | 1 | Converter did not become ready in time |

## Verification
The bench builds the reader with DIV_HALF=2, PWRUP_CYCLES=20 and TIMEOUT_CYCLES=50. With these values the power-up delay, a full 128-cycle frame and the exact cycle of a timeout all fit into a short run. That makes it practical to sweep a walking one and a walking zero through all 31 data bits, with conversion lengths that vary from frame to frame. Each frame's expected word, error flag and length follow directly from the pattern and from 64*DIV_HALF. Frames whose status bit is set, a single-cycle low glitch, and reads held off by `enable` are placed at exact cycle offsets.

// File: rtl/adc2w_reader.sv
`timescale 1ns/1ps
module adc2w_reader #(
  parameter int DIV_HALF       = 4,
  parameter int PWRUP_CYCLES   = 50000,
  parameter int TIMEOUT_CYCLES = 16000000,
  parameter int FRAME_BITS     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  sdo_in,
  output logic                  sclk,
  output logic [FRAME_BITS-1:0] result,
  output logic                  data_valid,
  output logic                  busy,
  output logic                  frame_err,
  output logic                  timeout_fault
);

  localparam int DW = $clog2(DIV_HALF + 1);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {S_PWRUP, S_IDLE, S_WAIT, S_SHIFT} st_t;

  st_t                  st;
  logic [PW-1:0]        pu_cnt;
  logic [TW-1:0]        to_cnt;
  logic [DW-1:0]        ph_cnt;
  logic [BW-1:0]        bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                 lo_seen;

  wire pu_done = (st != S_PWRUP);
  wire ph_end  = (ph_cnt == DW'(DIV_HALF - 1));
  wire rise    = (st == S_SHIFT) && ph_end && !sclk;
  wire fall    = (st == S_SHIFT) && ph_end && sclk;
  wire last    = fall && (bit_cnt == BW'(FRAME_BITS - 1));
  wire ready   = lo_seen && !sdo_in;

  assign busy = (st == S_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_PWRUP;
      pu_cnt        <= '0;
      to_cnt        <= '0;
      ph_cnt        <= '0;
      bit_cnt       <= '0;
      shreg         <= '0;
      lo_seen       <= 1'b0;
      sclk          <= 1'b0;
      result        <= '0;
      data_valid    <= 1'b0;
      frame_err     <= 1'b0;
      timeout_fault <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      case (st)
        S_PWRUP: begin
          if (pu_cnt == PW'(PWRUP_CYCLES - 1)) st <= S_IDLE;
          else pu_cnt <= pu_cnt + 1'b1;
        end
        S_IDLE: begin
          if (enable) begin
            st      <= S_WAIT;
            lo_seen <= 1'b0;
            to_cnt  <= '0;
          end
        end
        S_WAIT: begin
          if (!enable) begin
            st <= S_IDLE;
          end else if (ready) begin
            st            <= S_SHIFT;
            ph_cnt        <= '0;
            bit_cnt       <= '0;
            timeout_fault <= 1'b0;
          end else begin
            lo_seen <= !sdo_in;
            if (to_cnt == TW'(TIMEOUT_CYCLES - 1)) begin
              timeout_fault <= 1'b1;
              to_cnt        <= '0;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end
        end
        S_SHIFT: begin
          ph_cnt <= ph_end ? '0 : ph_cnt + 1'b1;
          if (ph_end) sclk <= !sclk;
          if (rise) shreg <= {shreg[FRAME_BITS-2:0], sdo_in};
          if (fall) bit_cnt <= bit_cnt + 1'b1;
          if (last) begin
            result     <= shreg;
            frame_err  <= shreg[FRAME_BITS-1];
            data_valid <= 1'b1;
            lo_seen    <= 1'b0;
            to_cnt     <= '0;
            st         <= enable ? S_WAIT : S_IDLE;
          end
        end
        default: st <= S_PWRUP;
      endcase
    end
  end

endmodule

// File: rtl/adc2w_reader_chk.sv
`timescale 1ns/1ps
module adc2w_reader_chk #(
  parameter int DIV_HALF   = 4,
  parameter int FRAME_BITS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pu_done,
  input logic                  sdo_in,
  input logic                  sclk,
  input logic [FRAME_BITS-1:0] result,
  input logic                  data_valid,
  input logic                  busy,
  input logic                  frame_err,
  input logic                  timeout_fault
);

  logic        sclk_p;
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      run    <= '0;
    end else begin
      sclk_p <= sclk;
      if (sclk != sclk_p) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 16'd1;
    end
  end

  assert_quiet_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_done |-> (!sclk && !busy));

  assert_two_lows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(sdo_in) && !$past(sdo_in, 2)));

  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_p && !sclk) |-> (run == 16'(DIV_HALF)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_valid || $stable(result)));

  assert_err_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (frame_err == result[FRAME_BITS-1]));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_valid || $stable(frame_err)));

  assert_fault_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !timeout_fault);

  assert_busy_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !busy);

endmodule

bind adc2w_reader adc2w_reader_chk #(
  .DIV_HALF  (DIV_HALF),
  .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pu_done      (pu_done),
  .sdo_in       (sdo_in),
  .sclk         (sclk),
  .result       (result),
  .data_valid   (data_valid),
  .busy         (busy),
  .frame_err    (frame_err),
  .timeout_fault(timeout_fault)
);

// File: tb/adc2w_reader_bench.sv
`timescale 1ns/1ps
module adc2w_reader_bench;
  localparam int DIV  = 2;
  localparam int PU   = 20;
  localparam int TOUT = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sdo = 1'b0;
  logic sclk, data_valid, busy, frame_err, timeout_fault;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int t_start = 0;
  logic busy_d = 1'b0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc2w_reader #(.DIV_HALF(DIV), .PWRUP_CYCLES(PU), .TIMEOUT_CYCLES(TOUT), .FRAME_BITS(32))
  u_adc2w_reader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sdo_in(sdo), .sclk(sclk),
    .result(result), .data_valid(data_valid), .busy(busy),
    .frame_err(frame_err), .timeout_fault(timeout_fault)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sclk) rise_cnt = rise_cnt + 1;
  always @(negedge clk) begin
    if (busy && !busy_d) t_start = cyc;
    busy_d = busy;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic conv_phase(input int n);
    sdo = 1'b1;
    repeat (n) @(posedge clk);
    #1 sdo = 1'b0;
  endtask

  task automatic finish_frame(input logic [31:0] w);
    int r0;
    r0 = rise_cnt;
    wait (busy === 1'b1);
    sdo = w[31];
    for (int i = 30; i >= 0; i--) begin
      @(negedge sclk);
      #1 sdo = w[i];
    end
    @(negedge sclk);
    #1 sdo = 1'b1;
    @(negedge clk);
    chk(data_valid === 1'b1, "R6 valid strobe", {31'd0, data_valid}, 32'd1);
    chk(result === w, "R5 captured word", result, w);
    chk(frame_err === w[31], "R7 error flag", {31'd0, frame_err}, {31'd0, w[31]});
    chk(busy === 1'b0, "R9 busy low at valid", {31'd0, busy}, 32'd0);
    chk(rise_cnt - r0 == 32, "R4 rising edges per frame", rise_cnt - r0, 32);
    chk(cyc - t_start == 64 * DIV, "R4 frame length", cyc - t_start, 64 * DIV);
    chk(timeout_fault === 1'b0, "R8 fault clear after frame", {31'd0, timeout_fault}, 32'd0);
    @(negedge clk);
    chk(data_valid === 1'b0, "R6 single cycle strobe", {31'd0, data_valid}, 32'd0);
    chk(result === w, "R6 result holds", result, w);
  endtask

  task automatic do_frame(input logic [31:0] w, input int conv);
    conv_phase(conv);
    finish_frame(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    enable = 1'b1;
    sdo = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sclk === 1'b0 && busy === 1'b0, "R1 reset outputs idle", {30'd0, sclk, busy}, 32'd0);
    chk(data_valid === 1'b0 && frame_err === 1'b0 && timeout_fault === 1'b0,
        "R6 reset flags", {29'd0, data_valid, frame_err, timeout_fault}, 32'd0);
    chk(result === 32'd0, "R6 reset result", result, 32'd0);
    rst_n = 1'b1;

    // R1: enable high and line low from reset, frame may start only at PU+3
    repeat (PU + 2) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1 no start inside power-up", {31'd0, busy}, 32'd0);
    chk(rise_cnt == 0, "R1 sclk held low in power-up", rise_cnt, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R1 start after power-up", {31'd0, busy}, 32'd1);
    finish_frame(32'h0123_4567);

    // R2: enable low keeps the reader quiet
    @(negedge clk);
    enable = 1'b0;
    sdo = 1'b0;
    r0 = rise_cnt;
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R2 no frame while disabled", {31'd0, busy}, 32'd0);
    chk(rise_cnt == r0, "R2 sclk quiet while disabled", rise_cnt - r0, 0);
    enable = 1'b1;
    finish_frame(32'h7E81_3C5A);

    // R3: single-cycle low ignored, two lows start
    repeat (4) @(negedge clk);
    sdo = 1'b0;
    @(negedge clk);
    sdo = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, "R3 one low sample ignored", {31'd0, busy}, 32'd0);
    sdo = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R3 not started after one low", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(busy === 1'b1, "R3 started after two lows", {31'd0, busy}, 32'd1);
    finish_frame(32'h5555_AAAA);

    // R5 R10: walking patterns over the data bits, back-to-back conversions
    for (int i = 0; i < 31; i++) begin
      do_frame(32'd1 << i, 2 + (i % 5));
      do_frame(~(32'd1 << i) & 32'h7FFF_FFFF, 3 + (i % 4));
    end

    // R7: status bit set in the captured frame
    do_frame(32'h8000_0000, 4);
    do_frame(32'hFFFF_FFFF, 2);
    do_frame(32'hA5A5_A5A5, 5);
    do_frame(32'h0000_0000, 3);

    // R8: timeout at the exact cycle, then cleared by the next frame
    @(negedge clk);
    enable = 1'b0;
    sdo = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    repeat (TOUT - 1) @(posedge clk);
    @(negedge clk);
    chk(timeout_fault === 1'b0, "R8 no fault before limit", {31'd0, timeout_fault}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(timeout_fault === 1'b1, "R8 fault at limit", {31'd0, timeout_fault}, 32'd1);
    repeat (10) @(negedge clk);
    chk(timeout_fault === 1'b1, "R8 fault held while waiting", {31'd0, timeout_fault}, 32'd1);
    do_frame(32'h1357_9BDF, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule